// File: doc/BRIEF.md
# Multi-level page table walker

The walker turns one virtual address into a physical address by reading page-table entries through a single memory port. It first works out the effective privilege from the current privilege, the modify-privilege flag and the previous-privilege field. When that privilege is machine, or when translation is switched off, it returns the address unchanged and touches no memory. Otherwise it walks a table whose shape is set by the translation mode: two levels of 10 index bits with 4-byte entries, three levels of 9 bits, or four levels of 9 bits, both with 8-byte entries.

During the walk it rejects non-canonical addresses and entry addresses beyond the end of memory. It follows pointer entries and checks the permissions of the leaf against the effective privilege and the access kind. It writes the referenced bit back into the leaf, and the dirty bit as well for stores. When the leaf sits above the last level, the low page-number bits of the virtual address fill in the physical page number. A request is taken only while the walker is idle. The answer comes back as a one-cycle pulse carrying either a physical address or a fault flag.

Top module: `pt_walker`

## Requirements
- R1: The effective privilege is `priv_i`. For loads and stores (access codes 0 and 1) with `priv_i` = machine (3) and `mprv_i` = 1, the effective privilege is `mpp_i` instead. Fetches (access code 2) always use `priv_i`. Privilege codes are user 0, supervisor 1, machine 3. Every code above user counts as supervisor for permission checks.
- R2: When `vm_mode_i` = 0 (bare), or the effective privilege is machine, the response carries `resp_paddr_o` = `req_vaddr_i` with no fault and no memory access.
- R3: `vm_mode_i` 1 selects 2 levels of 10 index bits with 4-byte entries, read and written with `mem_req_size_o` = 0. The upper 32 bits of `mem_rdata_i` are ignored for these entries. Mode 2 selects 3 levels of 9 bits and mode 3 selects 4 levels of 9 bits, both with 8-byte entries and `mem_req_size_o` = 1.
- R4: Let V be 12 plus levels times index bits. If the address bits from bit 63 down to bit V-1 are not all equal, the request faults with no memory read.
- R5: The walk starts with base = `root_ppn_i` << 12 at the top level. At level L, the index is `vaddr >> (12 + L*bits)` masked to the index width. The entry address is base + index times entry bytes. An entry address at or above `MEM_BYTES` faults without being read.
- R6: An entry with bit 0 (valid) and bit 1 (pointer) both set is a pointer. Its page number is the entry shifted right by 10. The next base is that page number << 12, one level down. A pointer found at level 0 faults.
- R7: Any other entry is a leaf. It faults if bit 0 is clear or bit 1 is set. A supervisor uses bits 5, 6 and 7 (read, write, execute). A user uses bits 2, 3 and 4. A load needs read, a store needs write and a fetch needs execute. A missing permission faults.
- R8: A permitted leaf is written back to the same address and size with bit 8 (referenced) set, and with bit 9 (dirty) also set for stores. No write is issued when the leaf already holds those bits.
- R9: A leaf at level L gives `resp_paddr_o` = ((page number | (vaddr[63:12] & (2^(L*bits) - 1))) << 12) | vaddr[11:0].
- R10: `req_ready_o` is high only while idle. `resp_valid_o` is a single-cycle pulse for each accepted request. A memory request stays high with a stable address and write enable until `mem_req_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | XLEN | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| priv_i | input | 2 | Current privilege |
| mprv_i | input | 1 | Modify-privilege flag |
| mpp_i | input | 2 | Previous privilege |
| vm_mode_i | input | 2 | Translation mode: 0 bare, 1/2/3 two/three/four levels |
| root_ppn_i | input | XLEN-12 | Root table page number |
| resp_valid_o | output | 1 | Response pulse |
| resp_fault_o | output | 1 | Translation faulted |
| resp_paddr_o | output | XLEN | Physical address |
| mem_req_valid_o | output | 1 | Memory request |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write-back |
| mem_req_size_o | output | 1 | 0: 4-byte entry, 1: 8-byte entry |
| mem_req_addr_o | output | XLEN | Entry byte address |
| mem_req_wdata_o | output | 64 | Write-back data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
The bench builds the walker with XLEN 64 and `MEM_BYTES` cut to 2 MiB, or 512 pages. With that limit, random pointers and root page numbers land past the end of memory often enough to exercise the range fault on every level. Random walks in all three table shapes mix leaves at every level, so superpages of each size come up. They also include invalid and pointer-at-bottom entries, non-canonical addresses and all privilege and modify-privilege combinations. The 4-byte shape is read back from storage whose upper word holds nonzero junk, so any use of those bits shows up in the result.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PG_SHIFT = 12;
  localparam int PPN_LSB  = 10;
  localparam int PTE_W    = 64;

  localparam int B_V   = 0;
  localparam int B_PTR = 1;
  localparam int B_UR  = 2;
  localparam int B_SR  = 5;
  localparam int B_REF = 8;
  localparam int B_DTY = 9;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {PRIV_USER = 2'd0, PRIV_SUP = 2'd1, PRIV_MACH = 2'd3} priv_e;
  typedef enum logic [1:0] {VM_BARE = 2'd0, VM_L2 = 2'd1, VM_L3 = 2'd2, VM_L4 = 2'd3} vm_e;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_WB, S_RESP} walk_st_e;

  // geometry g: 0 -> two levels, 1 -> three, 2 -> four
  function automatic int geo_bits(int g);
    return (g == 0) ? 10 : 9;
  endfunction
  function automatic int geo_bytes(int g);
    return (g == 0) ? 4 : 8;
  endfunction
  function automatic int geo_levels(int g);
    return g + 2;
  endfunction
endpackage

// File: rtl/pt_walker_mode_dec.sv
module pt_walker_mode_dec
  import pt_walker_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      priv_i,
  input  logic            mprv_i,
  input  logic [1:0]      mpp_i,
  input  logic [1:0]      vm_i,
  input  logic [1:0]      acc_i,
  input  logic [XLEN-1:0] vaddr_i,
  output logic            bypass_o,
  output logic            sup_o,
  output logic [1:0]      lvl_top_o,
  output logic            canon_o
);
  logic [1:0]      eff;
  int unsigned     va_bits;
  logic [XLEN-1:0] hi_bits;
  logic [XLEN-1:0] hi_ones;

  always_comb begin
    eff = priv_i;
    if (acc_i != ACC_FETCH && priv_i == PRIV_MACH && mprv_i) eff = mpp_i;
    if (vm_i == VM_BARE) eff = PRIV_MACH;
  end

  assign bypass_o = (eff == PRIV_MACH);
  assign sup_o    = (eff != PRIV_USER);

  always_comb begin
    case (vm_i)
      VM_L2:   begin lvl_top_o = 2'd1; va_bits = 32; end
      VM_L3:   begin lvl_top_o = 2'd2; va_bits = 39; end
      VM_L4:   begin lvl_top_o = 2'd3; va_bits = 48; end
      default: begin lvl_top_o = 2'd0; va_bits = 32; end
    endcase
  end

  // bits above the virtual width must replicate bit va_bits-1
  assign hi_bits = vaddr_i >> (va_bits - 1);
  assign hi_ones = {XLEN{1'b1}} >> (va_bits - 1);
  assign canon_o = (hi_bits == '0) || (hi_bits == hi_ones);
endmodule

// File: rtl/pt_walker_ent_addr.sv
module pt_walker_ent_addr
  import pt_walker_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      vm_i,
  input  logic [1:0]      lvl_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] vaddr_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] sp_mask_o
);
  localparam int N_GEO = 3;

  logic [XLEN-1:0] cand [N_GEO];
  logic [XLEN-1:0] msk  [N_GEO];

  for (genvar g = 0; g < N_GEO; g++) begin : g_geo
    localparam int BITS  = geo_bits(g);
    localparam int BYTES = geo_bytes(g);
    logic [XLEN-1:0] idx;
    assign idx     = (vaddr_i >> (PG_SHIFT + int'(lvl_i) * BITS)) & XLEN'((1 << BITS) - 1);
    assign cand[g] = base_i + idx * XLEN'(BYTES);
    assign msk[g]  = (XLEN'(1) << (int'(lvl_i) * BITS)) - XLEN'(1);
  end

  always_comb begin
    case (vm_i)
      VM_L3:   begin addr_o = cand[1]; sp_mask_o = msk[1]; end
      VM_L4:   begin addr_o = cand[2]; sp_mask_o = msk[2]; end
      default: begin addr_o = cand[0]; sp_mask_o = msk[0]; end
    endcase
  end
endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [9:0] pte_i,
  input  logic       sup_i,
  input  logic [1:0] acc_i,
  output logic       table_o,
  output logic       ok_o
);
  logic [2:0] rwx;
  logic       need;

  assign table_o = pte_i[B_V] && pte_i[B_PTR];
  assign rwx     = sup_i ? pte_i[B_SR +: 3] : pte_i[B_UR +: 3];

  always_comb begin
    case (acc_i)
      ACC_STORE: need = rwx[1];
      ACC_FETCH: need = rwx[2];
      default:   need = rwx[0];
    endcase
  end

  assign ok_o = pte_i[B_V] && !pte_i[B_PTR] && need;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] MEM_BYTES = 64'h0000_0001_0000_0000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [XLEN-1:0]          req_vaddr_i,
  input  logic [1:0]               req_acc_i,
  input  logic [1:0]               priv_i,
  input  logic                     mprv_i,
  input  logic [1:0]               mpp_i,
  input  logic [1:0]               vm_mode_i,
  input  logic [XLEN-PG_SHIFT-1:0] root_ppn_i,
  output logic                     resp_valid_o,
  output logic                     resp_fault_o,
  output logic [XLEN-1:0]          resp_paddr_o,
  output logic                     mem_req_valid_o,
  input  logic                     mem_req_ready_i,
  output logic                     mem_req_we_o,
  output logic                     mem_req_size_o,
  output logic [XLEN-1:0]          mem_req_addr_o,
  output logic [PTE_W-1:0]         mem_req_wdata_o,
  input  logic                     mem_rvalid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i
);
  localparam logic [XLEN-1:0] MEM_LIM = XLEN'(MEM_BYTES);

  walk_st_e         state_q;
  logic [XLEN-1:0]  vaddr_q, base_q, paddr_q, ent_addr_q;
  logic [1:0]       acc_q, vm_q, lvl_q;
  logic             sup_q, fault_q;
  logic [PTE_W-1:0] pte_q, wb_q;

  logic             dec_bypass, dec_sup, dec_canon;
  logic [1:0]       dec_lvl_top;
  logic [XLEN-1:0]  ent_addr, sp_mask;
  logic             ent_in_range, entry8;
  logic             pte_table, pte_ok;
  logic [XLEN-1:0]  ppn, vpn, leaf_pa;
  logic [PTE_W-1:0] wb_val;

  pt_walker_mode_dec #(.XLEN(XLEN)) u_dec (
    .priv_i    (priv_i),
    .mprv_i    (mprv_i),
    .mpp_i     (mpp_i),
    .vm_i      (vm_mode_i),
    .acc_i     (req_acc_i),
    .vaddr_i   (req_vaddr_i),
    .bypass_o  (dec_bypass),
    .sup_o     (dec_sup),
    .lvl_top_o (dec_lvl_top),
    .canon_o   (dec_canon)
  );

  pt_walker_ent_addr #(.XLEN(XLEN)) u_ent (
    .vm_i      (vm_q),
    .lvl_i     (lvl_q),
    .base_i    (base_q),
    .vaddr_i   (vaddr_q),
    .addr_o    (ent_addr),
    .sp_mask_o (sp_mask)
  );

  pt_walker_perm u_perm (
    .pte_i   (pte_q[9:0]),
    .sup_i   (sup_q),
    .acc_i   (acc_q),
    .table_o (pte_table),
    .ok_o    (pte_ok)
  );

  assign ent_in_range = (ent_addr < MEM_LIM);
  assign entry8       = (vm_q != VM_L2);
  assign ppn          = XLEN'(pte_q >> PPN_LSB);
  assign vpn          = vaddr_q >> PG_SHIFT;
  assign leaf_pa      = ((ppn | (vpn & sp_mask)) << PG_SHIFT)
                      | (vaddr_q & XLEN'((1 << PG_SHIFT) - 1));
  assign wb_val       = pte_q | (PTE_W'(1) << B_REF)
                      | (PTE_W'(acc_q == ACC_STORE) << B_DTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      vaddr_q    <= '0;
      base_q     <= '0;
      paddr_q    <= '0;
      ent_addr_q <= '0;
      acc_q      <= '0;
      vm_q       <= '0;
      lvl_q      <= '0;
      sup_q      <= 1'b0;
      fault_q    <= 1'b0;
      pte_q      <= '0;
      wb_q       <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            acc_q   <= req_acc_i;
            vm_q    <= vm_mode_i;
            sup_q   <= dec_sup;
            lvl_q   <= dec_lvl_top;
            base_q  <= {root_ppn_i, {PG_SHIFT{1'b0}}};
            fault_q <= 1'b0;
            paddr_q <= req_vaddr_i;
            if (dec_bypass) begin
              state_q <= S_RESP;
            end else if (!dec_canon) begin
              fault_q <= 1'b1;
              state_q <= S_RESP;
            end else begin
              state_q <= S_RD;
            end
          end
        end
        S_RD: begin
          if (!ent_in_range) begin
            fault_q <= 1'b1;
            state_q <= S_RESP;
          end else if (mem_req_ready_i) begin
            ent_addr_q <= ent_addr;
            state_q    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rvalid_i) begin
            pte_q   <= entry8 ? mem_rdata_i : {32'b0, mem_rdata_i[31:0]};
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (pte_table) begin
            if (lvl_q == 2'd0) begin
              fault_q <= 1'b1;
              state_q <= S_RESP;
            end else begin
              base_q  <= ppn << PG_SHIFT;
              lvl_q   <= lvl_q - 2'd1;
              state_q <= S_RD;
            end
          end else if (!pte_ok) begin
            fault_q <= 1'b1;
            state_q <= S_RESP;
          end else begin
            paddr_q <= leaf_pa;
            wb_q    <= wb_val;
            state_q <= (wb_val != pte_q) ? S_WB : S_RESP;
          end
        end
        S_WB: begin
          if (mem_req_ready_i) state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign resp_valid_o    = (state_q == S_RESP);
  assign resp_fault_o    = fault_q;
  assign resp_paddr_o    = fault_q ? '0 : paddr_q;
  assign mem_req_valid_o = (state_q == S_RD && ent_in_range) || (state_q == S_WB);
  assign mem_req_we_o    = (state_q == S_WB);
  assign mem_req_size_o  = entry8;
  assign mem_req_addr_o  = (state_q == S_WB) ? ent_addr_q : ent_addr;
  assign mem_req_wdata_o = wb_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] MEM_BYTES = 64'h0000_0001_0000_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             resp_valid_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_we_o,
  input logic             mem_req_size_o,
  input logic [XLEN-1:0]  mem_req_addr_o,
  input logic [PTE_W-1:0] mem_req_wdata_o
);
  localparam logic [XLEN-1:0] MEM_LIM = XLEN'(MEM_BYTES);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o));

  p_resp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !resp_valid_o);

  p_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o < MEM_LIM);

  p_align8_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_size_o |-> mem_req_addr_o[2:0] == 3'b0);

  p_align4_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_size_o |->
      mem_req_addr_o[1:0] == 2'b0 && mem_req_wdata_o[63:32] == 32'b0);

  p_wb_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[B_REF] && mem_req_wdata_o[B_V]);
endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_size_o  (mem_req_size_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int          XLEN = 64;
  localparam logic [63:0] MEMB = 64'h0020_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, priv = '0, mpp = '0, vm = '0;
  logic        mprv = 1'b0;
  logic [51:0] root = '0;
  logic        resp_valid, resp_fault;
  logic [63:0] resp_paddr;
  logic        mreq_valid, mreq_ready = 1'b0, mreq_we, mreq_size;
  logic [63:0] mreq_addr, mreq_wdata;
  logic        mrvalid = 1'b0;
  logic [63:0] mrdata = '0;

  pt_walker #(.XLEN(XLEN), .MEM_BYTES(MEMB)) u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_acc_i(req_acc), .priv_i(priv), .mprv_i(mprv), .mpp_i(mpp),
    .vm_mode_i(vm), .root_ppn_i(root),
    .resp_valid_o(resp_valid), .resp_fault_o(resp_fault), .resp_paddr_o(resp_paddr),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_req_we_o(mreq_we),
    .mem_req_size_o(mreq_size), .mem_req_addr_o(mreq_addr), .mem_req_wdata_o(mreq_wdata),
    .mem_rvalid_i(mrvalid), .mem_rdata_i(mrdata)
  );

  logic [63:0] mem_q [logic [63:0]];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        last_rsize = 1'b0;
  logic [63:0] last_wdata = '0;
  int          checks = 0, fails = 0;

  function automatic logic [63:0] mrd(input logic [63:0] a);
    return mem_q.exists(a) ? mem_q[a] : 64'h0;
  endfunction

  // memory model: random accept stalls, read data one cycle after accept
  always @(posedge clk) begin
    logic [63:0] old;
    mrvalid <= 1'b0;
    if (rst_n && mreq_valid && mreq_ready) begin
      if (mreq_we) begin
        wr_cnt++;
        last_wdata = mreq_wdata;
        old = mrd(mreq_addr);
        mem_q[mreq_addr] = mreq_size ? mreq_wdata : {old[63:32], mreq_wdata[31:0]};
      end else begin
        rd_cnt++;
        last_rsize = mreq_size;
        mrvalid <= 1'b1;
        mrdata  <= mrd(mreq_addr);
      end
    end
    mreq_ready <= ($urandom_range(3) != 0);
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench-side expectation
  logic        e_fault, e_wb;
  logic [63:0] e_paddr, e_wdata;
  int          e_reads;

  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] pv,
                          input logic mp, input logic [1:0] pp, input logic [1:0] vmm,
                          input logic [51:0] rt);
    logic [1:0]  eff;
    int          lv, bits, bytes, vab, sh;
    logic [63:0] hi, base, idx, a, pte, nw;
    logic [2:0]  rwx;
    logic        need, sup;
    e_fault = 1'b1; e_wb = 1'b0; e_paddr = '0; e_wdata = '0; e_reads = 0;
    eff = pv;
    if (acc != 2'd2 && pv == 2'd3 && mp) eff = pp;
    if (vmm == 2'd0) eff = 2'd3;
    if (eff == 2'd3) begin e_fault = 1'b0; e_paddr = va; return; end
    sup   = (eff != 2'd0);
    lv    = (vmm == 2'd1) ? 2 : (vmm == 2'd2) ? 3 : 4;
    bits  = (vmm == 2'd1) ? 10 : 9;
    bytes = (vmm == 2'd1) ? 4 : 8;
    vab   = 12 + lv * bits;
    hi    = va >> (vab - 1);
    if (hi != 0 && hi != ({64{1'b1}} >> (vab - 1))) return;
    base = {rt, 12'h0};
    for (int i = lv - 1; i >= 0; i--) begin
      sh  = i * bits;
      idx = (va >> (12 + sh)) & ((64'd1 << bits) - 1);
      a   = base + idx * bytes;
      if (a >= MEMB) return;
      e_reads++;
      pte = mrd(a);
      if (bytes == 4) pte = {32'h0, pte[31:0]};
      if (pte[0] && pte[1]) begin
        base = (pte >> 10) << 12;
        continue;
      end
      rwx  = sup ? pte[7:5] : pte[4:2];
      need = (acc == 2'd1) ? rwx[1] : (acc == 2'd2) ? rwx[2] : rwx[0];
      if (!pte[0] || pte[1] || !need) return;
      e_fault = 1'b0;
      e_paddr = (((pte >> 10) | ((va >> 12) & ((64'd1 << sh) - 1))) << 12) | {52'h0, va[11:0]};
      nw      = pte | 64'h100 | ((acc == 2'd1) ? 64'h200 : 64'h0);
      e_wb    = (nw != pte);
      e_wdata = nw;
      return;
    end
  endtask

  task automatic xact(input string req, input logic [63:0] va, input logic [1:0] acc,
                      input logic [1:0] pv, input logic mp, input logic [1:0] pp,
                      input logic [1:0] vmm, input logic [51:0] rt);
    int r0, w0, n;
    ref_walk(va, acc, pv, mp, pp, vmm, rt);
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_vaddr = va; req_acc = acc; priv = pv; mprv = mp; mpp = pp; vm = vmm; root = rt;
    chk("R10", "ready_when_idle", {63'h0, req_ready}, 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 1000) begin @(negedge clk); n++; end
    chk("R10", "response_seen", {63'h0, resp_valid}, 64'd1);
    chk(req, "fault", {63'h0, resp_fault}, {63'h0, e_fault});
    if (!e_fault) chk(req, "paddr", resp_paddr, e_paddr);
    chk(req, "reads", 64'(rd_cnt - r0), 64'(e_reads));
    chk("R8", "writes", 64'(wr_cnt - w0), {63'h0, e_wb});
    if (e_wb && wr_cnt != w0) chk("R8", "wdata", last_wdata, e_wdata);
    @(negedge clk);
    chk("R10", "resp_one_cycle", {63'h0, resp_valid}, 64'd0);
  endtask

  task automatic put(input logic [1:0] vmm, input logic [63:0] a, input logic [63:0] v);
    mem_q[a] = (vmm == 2'd1) ? {32'hC0DE_5A5A, v[31:0]} : v;
  endtask

  logic [63:0] va_r, a_r, base_r, pte_r;
  logic [1:0]  vm_r, acc_r, pv_r, pp_r;
  logic [51:0] rt_r;
  logic        mp_r;

  task automatic build_random();
    int lv, bits, bytes, vab, sh;
    logic [1:0] pl [3];
    pl[0] = 2'd0; pl[1] = 2'd1; pl[2] = 2'd3;
    mem_q.delete();
    vm_r  = ($urandom_range(15) == 0) ? 2'd0 : 2'($urandom_range(1, 3));
    acc_r = 2'($urandom_range(2));
    pv_r  = pl[$urandom_range(2)];
    pp_r  = pl[$urandom_range(2)];
    mp_r  = 1'($urandom_range(1));
    rt_r  = ($urandom_range(19) == 0) ? 52'($urandom_range(512, 700)) : 52'($urandom_range(1, 511));
    lv    = (vm_r == 2'd1) ? 2 : (vm_r == 2'd2) ? 3 : 4;
    bits  = (vm_r == 2'd1) ? 10 : 9;
    bytes = (vm_r == 2'd1) ? 4 : 8;
    vab   = 12 + lv * bits;
    va_r  = {$urandom, $urandom};
    if ($urandom_range(15) != 0)
      va_r = va_r[vab-1] ? (va_r | ({64{1'b1}} << vab)) : (va_r & ~({64{1'b1}} << vab));
    base_r = {rt_r, 12'h0};
    for (int i = lv - 1; i >= 0; i--) begin
      sh  = i * bits;
      a_r = base_r + ((va_r >> (12 + sh)) & ((64'd1 << bits) - 1)) * bytes;
      if (a_r >= MEMB) break;
      if (i > 0 && $urandom_range(2) != 0) begin
        pte_r = ($urandom_range(19) == 0) ? 64'($urandom_range(512, 700)) : 64'($urandom_range(1, 511));
        put(vm_r, a_r, (pte_r << 10) | 64'h3);
        base_r = pte_r << 12;
      end else begin
        pte_r = (64'($urandom_range(0, 1 << 20)) << 10) | 64'($urandom_range(0, 255) << 2) | 64'h1;
        if ($urandom_range(9) == 0) pte_r[0] = 1'b0;
        if ($urandom_range(9) == 0) pte_r = 64'h3 | (64'd5 << 10);
        put(vm_r, a_r, pte_r);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10", "reset_ready", {63'h0, req_ready}, 64'd1);
    chk("R10", "reset_resp", {63'h0, resp_valid}, 64'd0);
    chk("R10", "reset_memreq", {63'h0, mreq_valid}, 64'd0);
    rst_n = 1'b1;

    // R2: machine privilege and bare mode bypass
    xact("R2", 64'hFEDC_BA98_7654_3210, 2'd0, 2'd3, 1'b0, 2'd0, 2'd3, 52'd1);
    chk("R2", "machine_passthru", resp_paddr, 64'hFEDC_BA98_7654_3210);
    xact("R2", 64'h0123_4567_89AB_CDEF, 2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 52'd1);
    chk("R2", "bare_passthru", resp_paddr, 64'h0123_4567_89AB_CDEF);

    // three-level 4 KiB page, supervisor read/write leaf
    mem_q.delete();
    put(2'd2, 64'h1008, (64'd2 << 10) | 64'h3);
    put(2'd2, 64'h2008, (64'd3 << 10) | 64'h3);
    put(2'd2, 64'h3018, 64'h1D_DC61);
    xact("R5", 64'h4020_3ABC, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 52'd1);
    chk("R9", "l3_page_pa", resp_paddr, 64'h77_7ABC);
    chk("R8", "ref_written", last_wdata, 64'h1D_DD61);
    chk("R3", "size8", {63'h0, last_rsize}, 64'd1);
    xact("R8", 64'h4020_3ABC, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 52'd1);
    xact("R8", 64'h4020_3ABC, 2'd1, 2'd1, 1'b0, 2'd0, 2'd2, 52'd1);
    chk("R8", "dirty_written", last_wdata, 64'h1D_DF61);
    // R1: modify-privilege with user previous privilege; fetch ignores it
    xact("R1", 64'h4020_3ABC, 2'd0, 2'd3, 1'b1, 2'd0, 2'd2, 52'd1);
    chk("R1", "mprv_user_fault", {63'h0, resp_fault}, 64'd1);
    xact("R1", 64'h4020_3ABC, 2'd2, 2'd3, 1'b1, 2'd0, 2'd2, 52'd1);
    chk("R1", "fetch_machine", resp_paddr, 64'h4020_3ABC);
    xact("R1", 64'h4020_3ABC, 2'd1, 2'd3, 1'b1, 2'd1, 2'd2, 52'd1);
    chk("R1", "mprv_sup_ok", resp_paddr, 64'h77_7ABC);

    // R9: 1 GiB superpage leaf at the top level
    mem_q.delete();
    put(2'd2, 64'h1008, 64'h1000_0021);
    xact("R9", 64'h4020_3ABC, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 52'd1);
    chk("R9", "superpage_pa", resp_paddr, 64'h4020_3ABC);

    // R4: non-canonical four-level address
    xact("R4", 64'h0000_8000_0000_0000, 2'd0, 2'd1, 1'b0, 2'd0, 2'd3, 52'd1);
    chk("R4", "noncanon_fault", {63'h0, resp_fault}, 64'd1);

    // R6: pointer at the last level
    mem_q.delete();
    put(2'd2, 64'h1008, (64'd2 << 10) | 64'h3);
    put(2'd2, 64'h2008, (64'd3 << 10) | 64'h3);
    put(2'd2, 64'h3018, (64'd3 << 10) | 64'h3);
    xact("R6", 64'h4020_3ABC, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 52'd1);
    chk("R6", "ptr_bottom_fault", {63'h0, resp_fault}, 64'd1);

    // R5: root beyond memory
    xact("R5", 64'h4020_3ABC, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 52'h200);
    chk("R5", "root_oob_fault", {63'h0, resp_fault}, 64'd1);

    // R3: two-level, 4-byte entries with junk in the upper word
    mem_q.delete();
    put(2'd1, 64'h4004, 64'h1403);
    put(2'd1, 64'h5004, 64'h4_8C05);
    xact("R3", 64'h0040_1234, 2'd0, 2'd0, 1'b0, 2'd0, 2'd1, 52'd4);
    chk("R3", "l2_pa", resp_paddr, 64'h12_3234);
    chk("R3", "size4", {63'h0, last_rsize}, 64'd0);
    chk("R8", "l2_wdata", last_wdata, 64'h4_8D05);
    // R7: user fetch without execute
    xact("R7", 64'h0040_1234, 2'd2, 2'd0, 1'b0, 2'd0, 2'd1, 52'd4);
    chk("R7", "no_exec_fault", {63'h0, resp_fault}, 64'd1);
    xact("R7", 64'h0040_1234, 2'd1, 2'd0, 1'b0, 2'd0, 2'd1, 52'd4);
    chk("R7", "no_write_fault", {63'h0, resp_fault}, 64'd1);

    for (int t = 0; t < 400; t++) begin
      build_random();
      xact("R9", va_r, acc_r, pv_r, mp_r, pp_r, vm_r, rt_r);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule